// File: doc/BRIEF.md
# Divided Countdown Timer with Local Interrupt Entry

This block is a per-processor countdown timer. Software loads a start value, and the counter then counts down at the input clock rate divided by a programmable power of two. When the counter expires, the block records one pending timer event. A local interrupt entry supplies the vector for that event, a mask bit and a periodic bit. If the periodic bit is set, the counter reloads itself from the start value. Otherwise it stops at zero.

Pending events are offered to the interrupt controller only while the controller is enabled and the entry is unmasked. Each accepted offer consumes one event. A global software-enable level gates the whole entry. While it is low, the mask bit is held set and all pending events are discarded. The register bus protocol lies outside this block: each register has a plain write strobe with write data and a plain read-back output.

Top module: `lvt_countdown_timer`

## Requirements
- R1: The divide configuration is 4 bits and reads back as written. The bits {3,1,0}, taken as a 3-bit code, are incremented by one modulo 8, and the result is the exponent e of the divisor 2^e. Bit 2 has no effect. Examples: 4'hB gives divide-by-1, 4'h0 and 4'h4 give 2, 4'h1 gives 4, 4'h7 gives 16, 4'h8 gives 32, 4'hA gives 128.
- R2: A start-value write cancels any running countdown, clears the prescaler and loads both the start value and the current count with the written value on that edge. The current count then drops by one at every d-th clock edge, where d is the divisor.
- R3: A start value of zero leaves the timer stopped, and the current count reads zero for as long as the start value is zero.
- R4: Without the periodic bit, the edge that takes the count from 1 down to 0 is the single expiry, and the count then stays at zero.
- R5: With the periodic bit, the expiring edge reloads the current count with the start value, so a start value of N expires once every N divided ticks.
- R6: Each expiry adds one to the pending-event counter, which saturates at 255. Events are counted while the entry is masked.
- R7: The interrupt request is high only when the software enable is high, the mask bit is clear and at least one event is pending. Its vector is entry bits [7:0].
- R8: An acknowledge while the request is high removes one pending event. If an expiry and an accepted acknowledge fall on the same edge, the count is unchanged. An acknowledge with nothing pending has no effect.
- R9: While the software enable is low, the mask bit (entry bit 16) is forced set, the pending count is zero, and entry writes are stored with the mask bit set. The mask stays set after re-enabling until the entry is rewritten.
- R10: An entry write keeps only the vector (bits 7:0), the delivery-status bit (bit 12), the mask bit (bit 16) and the periodic bit (bit 17). All other bits read as zero.
- R11: After reset the current count is zero, the entry reads 32'h0001_0000 (masked), nothing is pending and the request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sw_enable_i | input | 1 | Global software enable of the controller |
| div_we_i | input | 1 | Divide configuration write strobe |
| div_wdata_i | input | 4 | Divide configuration write data |
| div_cfg_o | output | 4 | Divide configuration read-back |
| start_we_i | input | 1 | Start value write strobe |
| start_wdata_i | input | 32 | Start value write data |
| entry_we_i | input | 1 | Interrupt entry write strobe |
| entry_wdata_i | input | 32 | Interrupt entry write data |
| entry_o | output | 32 | Interrupt entry read-back |
| cur_count_o | output | 32 | Live current count |
| irq_req_o | output | 1 | Timer interrupt request |
| irq_vector_o | output | 8 | Vector of the requested interrupt |
| irq_ack_i | input | 1 | Request accepted; consumes one event |
| pending_o | output | 8 | Number of pending timer events |

## Verification
Expiry and acknowledge are the two functions that can land on the same edge. The bench forces this with a periodic timer whose start value is 1, so the timer expires on every edge, and holds the acknowledge high across several of those edges. The pending count must stay flat both below and at the 255 ceiling. A start-value write on an edge where expiry would otherwise occur must also leave the count unchanged. Software disable arriving in the same window as an expiry is judged by requiring zero pending events and a set mask bit one edge later.

// File: rtl/lvtmr_pkg.sv
package lvtmr_pkg;
  localparam int unsigned ENTRY_W  = 32;
  localparam int unsigned VEC_W    = 8;
  localparam int unsigned STAT_BIT = 12;
  localparam int unsigned MASK_BIT = 16;
  localparam int unsigned PER_BIT  = 17;
  localparam int unsigned EXP_W    = 3;

  localparam logic [ENTRY_W-1:0] ENTRY_KEEP =
      (ENTRY_W'(1) << PER_BIT) | (ENTRY_W'(1) << MASK_BIT) |
      (ENTRY_W'(1) << STAT_BIT) | ((ENTRY_W'(1) << VEC_W) - ENTRY_W'(1));
  localparam logic [ENTRY_W-1:0] ENTRY_RST = ENTRY_W'(1) << MASK_BIT;

  // code {3,1,0} plus one, wrapping, is the divisor exponent
  function automatic logic [EXP_W-1:0] div_exp(input logic [3:0] cfg);
    logic [EXP_W-1:0] code;
    code = {cfg[3], cfg[1], cfg[0]};
    return code + EXP_W'(1);
  endfunction
endpackage

// File: rtl/lvtmr_prescaler.sv
module lvtmr_prescaler #(
  parameter int unsigned EXP_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o
);
  localparam int unsigned PSC_W = (1 << EXP_W) - 1;

  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] lim;

  assign lim    = (PSC_W'(1) << exp_i) - PSC_W'(1);
  assign tick_o = run_i && (psc_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     psc_q <= '0;
    else if (restart_i || !run_i)    psc_q <= '0;
    else if (tick_o)                 psc_q <= '0;
    else                             psc_q <= psc_q + PSC_W'(1);
  end

  assert_idle_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i || !run_i) |=> psc_q == '0);
endmodule

// File: rtl/lvtmr_count.sv
module lvtmr_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  input  logic             periodic_i,
  output logic [CNT_W-1:0] cur_o,
  output logic             run_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] start_q, cur_q;

  assign run_o    = cur_q != '0;
  assign expire_o = tick_i && !load_i && (cur_q == CNT_W'(1));
  assign cur_o    = (start_q == '0) ? '0 : cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      cur_q   <= '0;
    end else if (load_i) begin
      start_q <= load_val_i;
      cur_q   <= load_val_i;
    end else if (tick_i) begin
      if (cur_q == CNT_W'(1)) cur_q <= periodic_i ? start_q : '0;
      else                    cur_q <= cur_q - CNT_W'(1);
    end
  end

  assert_zero_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_q == '0) |-> (cur_q == '0));
  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && cur_q > CNT_W'(1)) |=> cur_q == $past(cur_q) - CNT_W'(1));
  assert_oneshot_stop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !periodic_i) |=> cur_q == '0);
  assert_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && periodic_i) |=> cur_q == start_q);
endmodule

// File: rtl/lvtmr_entry.sv
module lvtmr_entry
  import lvtmr_pkg::*;
#(
  parameter int unsigned PEND_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sw_en_i,
  input  logic               we_i,
  input  logic [ENTRY_W-1:0] wdata_i,
  input  logic               expire_i,
  input  logic               ack_i,
  output logic [ENTRY_W-1:0] entry_o,
  output logic               periodic_o,
  output logic               irq_req_o,
  output logic [VEC_W-1:0]   irq_vector_o,
  output logic [PEND_W-1:0]  pending_o
);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic [ENTRY_W-1:0] entry_q, entry_d;
  logic [PEND_W-1:0]  pend_q;
  logic               dec;

  always_comb begin
    entry_d = we_i ? (wdata_i & ENTRY_KEEP) : entry_q;
    if (!sw_en_i) entry_d[MASK_BIT] = 1'b1;
  end

  assign irq_req_o    = sw_en_i && !entry_q[MASK_BIT] && (pend_q != '0);
  assign dec          = ack_i && irq_req_o;
  assign irq_vector_o = entry_q[VEC_W-1:0];
  assign periodic_o   = entry_q[PER_BIT];
  assign entry_o      = entry_q;
  assign pending_o    = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) entry_q <= ENTRY_RST;
    else         entry_q <= entry_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= '0;
    else if (!sw_en_i) pend_q <= '0;
    else begin
      unique case ({expire_i, dec})
        2'b10:   pend_q <= (pend_q == PEND_MAX) ? PEND_MAX : pend_q + PEND_W'(1);
        2'b01:   pend_q <= pend_q - PEND_W'(1);
        default: pend_q <= pend_q;
      endcase
    end
  end

  assert_mask_forced_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_en_i |=> entry_q[MASK_BIT]);
  assert_pending_cleared_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_en_i |=> pend_q == '0);
  assert_coincide_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_en_i && expire_i && dec) |=> pend_q == $past(pend_q));
  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_en_i && pend_q == PEND_MAX && !dec) |=> pend_q == PEND_MAX);
  assert_entry_bits_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry_q & ~ENTRY_KEEP) == '0);
endmodule

// File: rtl/lvt_countdown_timer.sv
module lvt_countdown_timer
  import lvtmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PEND_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sw_enable_i,
  input  logic               div_we_i,
  input  logic [3:0]         div_wdata_i,
  output logic [3:0]         div_cfg_o,
  input  logic               start_we_i,
  input  logic [CNT_W-1:0]   start_wdata_i,
  input  logic               entry_we_i,
  input  logic [ENTRY_W-1:0] entry_wdata_i,
  output logic [ENTRY_W-1:0] entry_o,
  output logic [CNT_W-1:0]   cur_count_o,
  output logic               irq_req_o,
  output logic [VEC_W-1:0]   irq_vector_o,
  input  logic               irq_ack_i,
  output logic [PEND_W-1:0]  pending_o
);
  logic [3:0]       div_q;
  logic [EXP_W-1:0] exp_w;
  logic             run, tick, expire, periodic;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       div_q <= '0;
    else if (div_we_i) div_q <= div_wdata_i;
  end

  assign div_cfg_o = div_q;
  assign exp_w     = div_exp(div_q);

  lvtmr_prescaler #(.EXP_W(EXP_W)) u_psc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .restart_i (start_we_i),
    .exp_i     (exp_w),
    .tick_o    (tick)
  );

  lvtmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start_we_i),
    .load_val_i (start_wdata_i),
    .tick_i     (tick),
    .periodic_i (periodic),
    .cur_o      (cur_count_o),
    .run_o      (run),
    .expire_o   (expire)
  );

  lvtmr_entry #(.PEND_W(PEND_W)) u_ent (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sw_en_i      (sw_enable_i),
    .we_i         (entry_we_i),
    .wdata_i      (entry_wdata_i),
    .expire_i     (expire),
    .ack_i        (irq_ack_i),
    .entry_o      (entry_o),
    .periodic_o   (periodic),
    .irq_req_o    (irq_req_o),
    .irq_vector_o (irq_vector_o),
    .pending_o    (pending_o)
  );

  assert_req_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (sw_enable_i && !entry_o[MASK_BIT] && pending_o != '0));
endmodule

// File: tb/lvt_countdown_timer_tb.sv
module lvt_countdown_timer_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sw_enable_i = 1'b1;
  logic        div_we_i = 1'b0;
  logic [3:0]  div_wdata_i = '0;
  logic [3:0]  div_cfg_o;
  logic        start_we_i = 1'b0;
  logic [31:0] start_wdata_i = '0;
  logic        entry_we_i = 1'b0;
  logic [31:0] entry_wdata_i = '0;
  logic [31:0] entry_o, cur_count_o;
  logic        irq_req_o;
  logic [7:0]  irq_vector_o;
  logic        irq_ack_i = 1'b0;
  logic [7:0]  pending_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  lvt_countdown_timer dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr_div(input logic [3:0] v);
    div_we_i = 1'b1; div_wdata_i = v; @(negedge clk_i); div_we_i = 1'b0;
  endtask

  task automatic wr_start(input logic [31:0] v);
    start_we_i = 1'b1; start_wdata_i = v; @(negedge clk_i); start_we_i = 1'b0;
  endtask

  task automatic wr_entry(input logic [31:0] v);
    entry_we_i = 1'b1; entry_wdata_i = v; @(negedge clk_i); entry_we_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 count", cur_count_o, 0);
    chk("R11 entry", entry_o, 32'h0001_0000);
    chk("R11 pending", {24'd0, pending_o}, 0);
    chk("R11 req", {31'd0, irq_req_o}, 0);
  endtask

  task automatic t_entry_bits;
    wr_entry(32'hFFFF_FFFF);
    chk("R10 kept bits", entry_o, 32'h0003_10FF);
    wr_entry(32'h0000_0000);
    chk("R10 cleared", entry_o, 0);
  endtask

  task automatic t_div(input logic [3:0] cfg, input int d);
    wr_div(cfg);
    chk("R1 readback", {28'd0, div_cfg_o}, {28'd0, cfg});
    wr_start(1000);
    chk("R2 loaded", cur_count_o, 1000);
    step(d - 1);
    chk("R1 before tick", cur_count_o, 1000);
    step(1);
    chk("R1 first tick", cur_count_o, 999);
    step(d);
    chk("R2 second tick", cur_count_o, 998);
  endtask

  task automatic t_zero_stop;
    wr_start(0);
    chk("R3 zero write", cur_count_o, 0);
    step(10);
    chk("R3 stays zero", cur_count_o, 0);
  endtask

  task automatic t_oneshot;
    wr_div(4'hB);
    wr_entry(32'h0000_0040);
    wr_start(3);
    step(2);
    chk("R4 count 1", cur_count_o, 1);
    chk("R6 none yet", {24'd0, pending_o}, 0);
    step(1);
    chk("R4 expired", cur_count_o, 0);
    chk("R6 one event", {24'd0, pending_o}, 1);
    chk("R7 req", {31'd0, irq_req_o}, 1);
    chk("R7 vector", {24'd0, irq_vector_o}, 32'h40);
    step(5);
    chk("R4 stays stopped", cur_count_o, 0);
    chk("R4 no second event", {24'd0, pending_o}, 1);
    irq_ack_i = 1'b1; step(1); irq_ack_i = 1'b0;
    chk("R8 ack consumes", {24'd0, pending_o}, 0);
    chk("R8 req drops", {31'd0, irq_req_o}, 0);
  endtask

  task automatic t_periodic;
    wr_entry(32'h0002_0041);
    wr_start(4);
    step(4);
    chk("R5 reloaded", cur_count_o, 4);
    chk("R5 first event", {24'd0, pending_o}, 1);
    step(4);
    chk("R5 second event", {24'd0, pending_o}, 2);
    step(1);
    chk("R5 counting again", cur_count_o, 3);
    wr_entry(32'h0003_0041);
    chk("R6 counted while masked", {31'd0, pending_o != 0}, 1);
    chk("R7 masked no req", {31'd0, irq_req_o}, 0);
    wr_entry(32'h0002_0041);
    chk("R7 unmasked req", {31'd0, irq_req_o}, 1);
    chk("R7 vector", {24'd0, irq_vector_o}, 32'h41);
  endtask

  task automatic t_restart;
    wr_start(100);
    step(10);
    chk("R2 running", cur_count_o, 90);
    wr_start(50);
    chk("R2 restart value", cur_count_o, 50);
  endtask

  task automatic t_swdis;
    sw_enable_i = 1'b0; step(1);
    chk("R9 mask forced", {31'd0, entry_o[16]}, 1);
    chk("R9 pending cleared", {24'd0, pending_o}, 0);
    chk("R9 no req", {31'd0, irq_req_o}, 0);
    wr_entry(32'h0002_0041);
    chk("R9 write stored masked", entry_o, 32'h0003_0041);
    sw_enable_i = 1'b1; step(1);
    chk("R9 mask kept after enable", entry_o, 32'h0003_0041);
  endtask

  task automatic t_coincide;
    wr_start(0);
    sw_enable_i = 1'b0; step(1); sw_enable_i = 1'b1;
    wr_entry(32'h0002_0041);
    chk("R8 start clean", {24'd0, pending_o}, 0);
    wr_start(1);
    chk("R6 load edge no event", {24'd0, pending_o}, 0);
    step(2);
    chk("R6 event per edge", {24'd0, pending_o}, 2);
    irq_ack_i = 1'b1; step(5);
    chk("R8 expiry with ack holds", {24'd0, pending_o}, 2);
    irq_ack_i = 1'b0;
    wr_start(0);
    chk("R2 load suppresses expiry", {24'd0, pending_o}, 2);
    chk("R3 stopped", cur_count_o, 0);
  endtask

  task automatic t_sat;
    wr_start(1);
    step(300);
    chk("R6 saturates", {24'd0, pending_o}, 255);
    irq_ack_i = 1'b1; step(3); irq_ack_i = 1'b0;
    chk("R8 ack at ceiling holds", {24'd0, pending_o}, 255);
    wr_start(0);
    irq_ack_i = 1'b1; step(1); irq_ack_i = 1'b0;
    chk("R8 single ack", {24'd0, pending_o}, 254);
    sw_enable_i = 1'b0; step(1); sw_enable_i = 1'b1;
    wr_entry(32'h0000_0041);
    irq_ack_i = 1'b1; step(1); irq_ack_i = 1'b0;
    chk("R8 ack with none pending", {24'd0, pending_o}, 0);
    chk("R8 no req", {31'd0, irq_req_o}, 0);
  endtask

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(1);
    t_reset();
    t_entry_bits();
    t_div(4'hB, 1);
    t_div(4'h0, 2);
    t_div(4'h4, 2);
    t_div(4'h1, 4);
    t_div(4'h7, 16);
    t_div(4'h8, 32);
    t_div(4'hA, 128);
    t_zero_stop();
    t_oneshot();
    t_periodic();
    t_restart();
    t_swdis();
    t_coincide();
    t_sat();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule